// File: doc/BRIEF.md
# Power-Management Status and Control Register

This block holds the 32-bit power-management status and control word of one function in a PCI-style bridge. It sits behind a register port whose address decode is already done: a write strobe, write data and byte enables come in, and a registered image of the word goes out. A one-cycle event pulse from a hot-plug controller latches a sticky PME status bit. Software clears that bit by writing a one to it. When status and enable are both set, the block drives an active-low PME wake output.

The two-bit power-state field accepts only the full-power state (00) and the hot low-power state (11). A write that asks for either intermediate state (01 or 10) still completes on the bus, but the block drops the value and the stored state stays as it was. Each accepted write that changes the state produces a one-cycle change pulse. A hot-plug enable input decides whether the register exists at all. While that input is low, the word reads as zero, all writes and events are ignored, and the stored fields are held at their reset values.

Top module: `pm_ctl_reg`

## Requirements
- R1: After a synchronous reset, the read image is 0x0000_0000, `pme_n_o` is 1, `pstate_o` is 00 and `pstate_chg_o` is 0.
- R2: Bits 31:24, 22:16, 14:9 and 7:2 of the read image are always 0, and writes to them have no effect. Bit 23 is read-only and shows the `BUS_PM_OFF` parameter (default 0), which no write can change.
- R3: A one-cycle pulse on `pme_evt_i` sets status bit 15. The bit reads as 1 two clocks after the pulse is sampled.
- R4: Writing 1 to bit 15 with byte enable 1 set clears the status. Writing 0 to bit 15, or writing 1 with byte enable 1 clear, leaves the status unchanged.
- R5: If an event and a write-one-to-clear of bit 15 fall in the same cycle, the status ends up set.
- R6: Bit 8 is a read-write PME enable and is written only when byte enable 1 is set.
- R7: `pme_n_o` is 0 exactly when status (bit 15) and enable (bit 8) were both 1 one clock earlier, and 1 otherwise.
- R8: Bits 1:0 hold the power state: 00 is the full-power state and 11 is the hot low-power state. A write of either value is stored when byte enable 0 is set. `pstate_o` shows the stored state.
- R9: A write of 01 or 10 to bits 1:0 leaves the stored power state unchanged.
- R10: `pstate_chg_o` is high for one cycle after each accepted power-state write that changes the value. It stays low for a write of the same value and for a dropped write.
- R11: While `hp_en_i` is low, the read image is 0, `pme_n_o` is 1, writes and events are ignored, and all fields return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_en_i | input | 1 | Hot-plug enable; the register exists only while this is high |
| wr_en_i | input | 1 | Write strobe, already decoded for this register |
| wr_be_i | input | DATA_W/8 | Byte enables for the write |
| wr_data_i | input | DATA_W | Write data |
| pme_evt_i | input | 1 | One-cycle PME event pulse from the hot-plug controller |
| rd_data_o | output | DATA_W | Registered read image of the register |
| pme_n_o | output | 1 | Active-low PME wake output, registered |
| pstate_o | output | 2 | Current stored power state |
| pstate_chg_o | output | 1 | One-cycle pulse when an accepted write changes the power state |

## Verification
Inputs change on the falling edge, so the rising edge that follows is the capture point. The field registers update at that edge, which means `pstate_o` and `pstate_chg_o` can be checked at the next falling edge. The read image and `pme_n_o` each pass through one more register, so their checks come one falling edge later. An event is sampled at one edge and its status appears in the read image two edges later; each directed task waits exactly that many edges before it samples. Each task also checks that the change pulse has dropped one cycle later, and that `pme_n_o` has not yet moved in the cycle the enable is written.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;

  localparam int REG_W   = 32;
  localparam int PS_LSB  = 0;
  localparam int PS_W    = 2;
  localparam int EN_BIT  = 8;
  localparam int STS_BIT = 15;
  localparam int BPM_BIT = 23;

  typedef enum logic [PS_W-1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  function automatic logic ps_supported(input logic [PS_W-1:0] v);
    return (v == PS_D0) || (v == PS_D3HOT);
  endfunction

endpackage

// File: rtl/pm_wr_decode.sv
module pm_wr_decode
  import pm_csr_pkg::*;
#(
  parameter int DATA_W = REG_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              hp_en,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ps_we,
  output logic [PS_W-1:0]   ps_val,
  output logic              en_we,
  output logic              en_val,
  output logic              sts_clr
);

  logic [BE_W-1:0] lane_we;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_we[g] = hp_en & wr_en & wr_be[g];
  end

  assign ps_val  = wr_data[PS_LSB +: PS_W];
  assign ps_we   = lane_we[PS_LSB/8] & ps_supported(ps_val);
  assign en_we   = lane_we[EN_BIT/8];
  assign en_val  = wr_data[EN_BIT];
  assign sts_clr = lane_we[STS_BIT/8] & wr_data[STS_BIT];

  // reserved data bits and unused lanes are ignored on purpose
  logic unused_wr;
  assign unused_wr = ^{lane_we, wr_data};

endmodule

// File: rtl/pm_status_w1c.sv
module pm_status_w1c (
  input  logic clk,
  input  logic rst,
  input  logic hp_en,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst || !hp_en) begin
      q <= 1'b0;
    end else if (set) begin
      q <= 1'b1;
    end else if (clr) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/pm_pstate_ctl.sv
module pm_pstate_ctl
  import pm_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hp_en,
  input  logic            ps_we,
  input  logic [PS_W-1:0] ps_val,
  output logic [PS_W-1:0] ps_q,
  output logic            chg_q
);

  always_ff @(posedge clk) begin
    if (rst || !hp_en) begin
      ps_q  <= PS_D0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= ps_we && (ps_val != ps_q);
      if (ps_we) begin
        ps_q <= ps_val;
      end
    end
  end

endmodule

// File: rtl/pm_out_stage.sv
module pm_out_stage
  import pm_csr_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hp_en,
  input  logic [DATA_W-1:0] img,
  input  logic              sts,
  input  logic              en,
  output logic [DATA_W-1:0] rd_q,
  output logic              pme_n_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= '0;
      pme_n_q <= 1'b1;
    end else begin
      rd_q    <= hp_en ? img : '0;
      pme_n_q <= !(hp_en && sts && en);
    end
  end

endmodule

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import pm_csr_pkg::*;
#(
  parameter int   DATA_W     = REG_W,
  parameter logic BUS_PM_OFF = 1'b0,
  localparam int  BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hp_en_i,
  input  logic              wr_en_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pme_evt_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pme_n_o,
  output logic [1:0]        pstate_o,
  output logic              pstate_chg_o
);

  logic            ps_we, en_we, en_val, sts_clr;
  logic [PS_W-1:0] ps_val, ps_q;
  logic            sts_q, en_q, chg_q;
  logic [DATA_W-1:0] img;

  pm_wr_decode #(.DATA_W(DATA_W)) u_dec (
    .hp_en   (hp_en_i),
    .wr_en   (wr_en_i),
    .wr_be   (wr_be_i),
    .wr_data (wr_data_i),
    .ps_we   (ps_we),
    .ps_val  (ps_val),
    .en_we   (en_we),
    .en_val  (en_val),
    .sts_clr (sts_clr)
  );

  pm_status_w1c u_sts (
    .clk   (clk),
    .rst   (rst),
    .hp_en (hp_en_i),
    .set   (pme_evt_i),
    .clr   (sts_clr),
    .q     (sts_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !hp_en_i) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_val;
    end
  end

  pm_pstate_ctl u_ps (
    .clk    (clk),
    .rst    (rst),
    .hp_en  (hp_en_i),
    .ps_we  (ps_we),
    .ps_val (ps_val),
    .ps_q   (ps_q),
    .chg_q  (chg_q)
  );

  always_comb begin
    img                   = '0;
    img[BPM_BIT]          = BUS_PM_OFF;
    img[STS_BIT]          = sts_q;
    img[EN_BIT]           = en_q;
    img[PS_LSB +: PS_W]   = ps_q;
  end

  pm_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .hp_en   (hp_en_i),
    .img     (img),
    .sts     (sts_q),
    .en      (en_q),
    .rd_q    (rd_data_o),
    .pme_n_q (pme_n_o)
  );

  assign pstate_o     = ps_q;
  assign pstate_chg_o = chg_q;

endmodule

// File: rtl/pm_ctl_reg_chk.sv
module pm_ctl_reg_chk #(
  parameter int  DATA_W = 32,
  localparam int BE_W   = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hp_en_i,
  input logic              wr_en_i,
  input logic [BE_W-1:0]   wr_be_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              pme_evt_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              pme_n_o,
  input logic [1:0]        pstate_o,
  input logic              pstate_chg_o
);

  localparam logic [DATA_W-1:0] LIVE = DATA_W'(32'h0080_8103);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o & ~LIVE) == '0);

  p_evt_visible_r3: assert property (@(posedge clk) disable iff (rst)
    (pme_evt_i && hp_en_i) ##1 hp_en_i |=> rd_data_o[15]);

  p_pme_matches_image_r7: assert property (@(posedge clk) disable iff (rst)
    pme_n_o == !(rd_data_o[15] && rd_data_o[8]));

  p_state_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 2'b00) || (pstate_o == 2'b11));

  p_pulse_means_change_r10: assert property (@(posedge clk) disable iff (rst)
    pstate_chg_o |-> (pstate_o != $past(pstate_o)));

  p_absent_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !hp_en_i |=> (rd_data_o == '0) && pme_n_o);

  logic unused_chk;
  assign unused_chk = ^{wr_en_i, wr_be_i, wr_data_i};

endmodule

bind pm_ctl_reg pm_ctl_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pm_ctl_reg_tb.sv
module pm_ctl_reg_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hp_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        pme_evt_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        pme_n_o;
  logic [1:0]  pstate_o;
  logic        pstate_chg_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_ctl_reg u_dut (
    .clk          (clk),
    .rst          (rst),
    .hp_en_i      (hp_en_i),
    .wr_en_i      (wr_en_i),
    .wr_be_i      (wr_be_i),
    .wr_data_i    (wr_data_i),
    .pme_evt_i    (pme_evt_i),
    .rd_data_o    (rd_data_o),
    .pme_n_o      (pme_n_o),
    .pstate_o     (pstate_o),
    .pstate_chg_o (pstate_chg_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    wr_en_i = 1'b1; wr_data_i = d; wr_be_i = be;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0; wr_be_i = '0;
  endtask

  task automatic evt();
    pme_evt_i = 1'b1;
    tick();
    pme_evt_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd", rd_data_o, 32'h0);
    chk("R1 pme_n", 32'(pme_n_o), 32'h1);
    chk("R1 pstate", 32'(pstate_o), 32'h0);
    chk("R1 chg", 32'(pstate_chg_o), 32'h0);
  endtask

  task automatic t_reserved();
    wr(32'hFFFF_FFFF, 4'hF);
    chk("R8 pstate D3hot", 32'(pstate_o), 32'h3);
    chk("R10 pulse", 32'(pstate_chg_o), 32'h1);
    tick();
    chk("R10 pulse single", 32'(pstate_chg_o), 32'h0);
    chk("R2 reserved", rd_data_o, 32'h0000_0103);
    wr(32'h0, 4'hF);
    chk("R8 pstate D0", 32'(pstate_o), 32'h0);
    tick();
    chk("R2 cleared", rd_data_o, 32'h0);
  endtask

  task automatic t_pstate();
    wr(32'h1, 4'h1);
    chk("R9 D1 dropped", 32'(pstate_o), 32'h0);
    chk("R10 no pulse D1", 32'(pstate_chg_o), 32'h0);
    wr(32'h3, 4'h1);
    chk("R8 to D3hot", 32'(pstate_o), 32'h3);
    wr(32'h2, 4'h1);
    chk("R9 D2 dropped", 32'(pstate_o), 32'h3);
    chk("R10 no pulse D2", 32'(pstate_chg_o), 32'h0);
    wr(32'h3, 4'h1);
    chk("R10 same value", 32'(pstate_chg_o), 32'h0);
    wr(32'h0, 4'h2);
    chk("R8 byte0 off", 32'(pstate_o), 32'h3);
    wr(32'h0, 4'h1);
    chk("R8 back D0", 32'(pstate_o), 32'h0);
    tick();
  endtask

  task automatic t_event();
    evt();
    tick();
    chk("R3 status set", rd_data_o, 32'h0000_8000);
    chk("R7 no enable", 32'(pme_n_o), 32'h1);
  endtask

  task automatic t_w1c();
    wr(32'h0, 4'hF);
    tick();
    chk("R4 write0", 32'(rd_data_o[15]), 32'h1);
    wr(32'h0000_8000, 4'h1);
    tick();
    chk("R4 lane off", 32'(rd_data_o[15]), 32'h1);
    wr(32'h0000_8000, 4'h2);
    tick();
    chk("R4 cleared", rd_data_o, 32'h0);
  endtask

  task automatic t_pme();
    evt();
    wr(32'h0000_0100, 4'h1);
    tick();
    chk("R6 lane off", rd_data_o, 32'h0000_8000);
    wr(32'h0000_0100, 4'h2);
    chk("R7 not yet", 32'(pme_n_o), 32'h1);
    tick();
    chk("R7 asserted", 32'(pme_n_o), 32'h0);
    chk("R6 enable", rd_data_o, 32'h0000_8100);
    wr(32'h0, 4'h2);
    chk("R7 holds", 32'(pme_n_o), 32'h0);
    tick();
    chk("R7 released", 32'(pme_n_o), 32'h1);
  endtask

  task automatic t_race();
    pme_evt_i = 1'b1;
    wr(32'h0000_8000, 4'h2);
    pme_evt_i = 1'b0;
    tick();
    chk("R5 set wins", 32'(rd_data_o[15]), 32'h1);
    wr(32'h0000_8000, 4'h2);
    tick();
    chk("R4 clear after race", rd_data_o, 32'h0);
  endtask

  task automatic t_hp();
    evt();
    wr(32'h0000_0103, 4'h3);
    tick();
    chk("R7 pre", 32'(pme_n_o), 32'h0);
    hp_en_i = 1'b0;
    tick();
    chk("R11 rd zero", rd_data_o, 32'h0);
    chk("R11 pme_n", 32'(pme_n_o), 32'h1);
    chk("R11 pstate", 32'(pstate_o), 32'h0);
    wr(32'h0000_0103, 4'hF);
    evt();
    tick();
    chk("R11 rd still zero", rd_data_o, 32'h0);
    hp_en_i = 1'b1;
    tick();
    tick();
    chk("R11 fields reset", rd_data_o, 32'h0);
    chk("R11 pstate reset", 32'(pstate_o), 32'h0);
    chk("R11 pme_n reset", 32'(pme_n_o), 32'h1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_reserved();
    t_pstate();
    t_event();
    t_w1c();
    t_pme();
    t_race();
    t_hp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule